// File: doc/BRIEF.md
# Interrupt Collector with Priority Levels

This block gathers a bank of level-sensitive interrupt lines into one processor interrupt. Each line has its own control register holding an enable flag and a two-bit priority. Among the lines that are asserted and enabled, the block picks one winner. The highest priority wins, and between lines at the same priority the lowest line number wins. The winner's number is published in a status register.

Software services an interrupt in three steps. It reads the status register. It writes the number it read into the vector register, which marks that line's priority level as in service. When it has finished, it writes the level-acknowledge register to release that level. While a level is in service, the processor interrupt is raised only for a winner at a strictly higher level, so a higher level can preempt a lower one.

Every register sits in a 16-byte slot that has four word-aligned access aliases:
- +0x0 writes the value plainly.
- +0x4 ORs the data into the register.
- +0x8 clears the bits that are set in the data.
- +0xC toggles the bits that are set in the data.

A control register provides two functions. One holds all priorities at level 0 (soft reset). The other forces the processor interrupt low (gate).

Top module: `irq_collector`

## Requirements
- R1: Within a slot, the alias is selected by address bits [3:2]: 0 plain, 1 OR, 2 clear-where-one, 3 toggle-where-one. A write changes only the addressed register. A per-source register (byte 0x120 + 0x10*n) keeps only bit 2 (enable) and bits [1:0] (priority), and its other bits read as zero.
- R2: A read returns data on `bus_rdata` after the clock edge that samples `bus_rd`, and the data is held until the next read. Reads of unmapped or non-word-aligned addresses return zero, and writes to them change no register.
- R3: The winner is the asserted, enabled source with the highest priority (3 highest). Ties go to the lowest source number. A disabled source never wins.
- R4: Status (byte 0x70) reads {bit31 = winner valid, bits[6:0] = winner number}. With no winner it reads 0x0000007F.
- R5: With no level in service and the gate off, `cpu_irq` goes high at the first clock edge after a winner exists.
- R6: Writing source number n to the vector register (byte 0x00, which reads back bits [6:0]) marks n's priority level in service. `cpu_irq` then stays low unless the winner's level is above every in-service level.
- R7: A write to the level-acknowledge slot (byte 0x10) releases each level whose bit is set in `bus_wdata[3:0]`, so the value 0x1 releases level 0. Reading this slot returns the in-service levels in bits [3:0].
- R8: While control (byte 0x20) bit 31 is set, every source's priority is forced to level 0 and priority writes have no effect. Enable bits are kept.
- R9: While control bit 30 is set, `cpu_irq` is held low, and the status register still reports the winner.
- R10: After reset all registers are zero, `cpu_irq` is low and status reads 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | N_SRC | Level interrupt lines, synchronous to clk |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
A write sampled at edge t updates registers at t. `cpu_irq` reflects the new register state at edge t+1, and it reflects a change on `src_irq` made before edge t at edge t. Read data is due one edge after `bus_rd` is sampled. The bench drives every input on the falling edge and samples each read on the falling edge right after the capturing edge. It checks `cpu_irq` two falling edges after a stimulus, which covers the longest of these paths.

// File: rtl/icoll_pkg.sv
// Package: shared constants, the access-alias type and the alias write rule.
// Assumes 32-bit registers and a 2-bit priority field.
package icoll_pkg;
    localparam int DATA_W  = 32;
    localparam int PRIO_W  = 2;
    localparam int NUM_LVL = 1 << PRIO_W;

    typedef enum logic [1:0] {
        ACC_PLAIN = 2'd0,
        ACC_OR    = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_TOG   = 2'd3
    } acc_e;

    // Apply one alias operation to a current register value.
    function automatic logic [DATA_W-1:0] apply_acc(acc_e op,
                                                    logic [DATA_W-1:0] cur,
                                                    logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        case (op)
            ACC_PLAIN: r = d;
            ACC_OR:    r = cur | d;
            ACC_CLR:   r = cur & ~d;
            default:   r = cur ^ d;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/icoll_src_bank.sv
// Source bank: one enable flag and one priority field per interrupt source.
// Assumes one bus write per cycle, addressed by wr_idx. While soft_rst is
// high every priority is held at 0, and writes still update the enable.
module icoll_src_bank
    import icoll_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int SRC_W = $clog2(N_SRC)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  acc_e                         wr_op,
    input  logic [SRC_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         soft_rst,
    output logic [N_SRC-1:0]             src_en,
    output logic [N_SRC-1:0][PRIO_W-1:0] src_prio,
    output logic [PRIO_W:0]              rd_val
);
    localparam int FIELD_W = PRIO_W + 1;

    logic [FIELD_W-1:0] wr_new;

    // Current contents of the addressed source, shared by the read and write paths.
    assign rd_val = {src_en[wr_idx], src_prio[wr_idx]};

    // New field value after the alias operation; only the low field bits are kept.
    assign wr_new = FIELD_W'(apply_acc(wr_op, DATA_W'(rd_val), wr_data));

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Per-source register update, with soft reset forcing level 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_en[i]   <= 1'b0;
                src_prio[i] <= '0;
            end else begin
                if (wr_en && wr_idx == SRC_W'(i)) begin
                    src_en[i] <= wr_new[PRIO_W];
                end
                if (soft_rst) begin
                    src_prio[i] <= '0;
                end else if (wr_en && wr_idx == SRC_W'(i)) begin
                    src_prio[i] <= wr_new[PRIO_W-1:0];
                end
            end
        end
    end

    // R8: one cycle of soft reset leaves every priority at level 0.
    assert_soft_reset_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (src_prio == '0));
endmodule

// File: rtl/icoll_arbiter.sv
// Arbiter: picks the asserted, enabled source with the highest level, and
// the lowest number within that level. Purely combinational; clk and rst_n
// serve the local assertions only.
module icoll_arbiter
    import icoll_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int SRC_W = $clog2(N_SRC)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_SRC-1:0]             src_req,
    input  logic [N_SRC-1:0]             src_en,
    input  logic [N_SRC-1:0][PRIO_W-1:0] src_prio,
    output logic                         win_valid,
    output logic [PRIO_W-1:0]            win_lvl,
    output logic [SRC_W-1:0]             win_idx
);
    logic [NUM_LVL-1:0]            lvl_hit;
    logic [NUM_LVL-1:0][SRC_W-1:0] lvl_idx;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic             hit;
        logic [SRC_W-1:0] idx;

        // Lowest-numbered qualifying source at this level.
        always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int i = N_SRC - 1; i >= 0; i--) begin
                if (src_req[i] && src_en[i] && src_prio[i] == PRIO_W'(l)) begin
                    hit = 1'b1;
                    idx = SRC_W'(i);
                end
            end
        end

        assign lvl_hit[l] = hit;
        assign lvl_idx[l] = idx;
    end

    // Highest level with any candidate; the later iteration wins.
    always_comb begin
        win_valid = |lvl_hit;
        win_lvl   = '0;
        win_idx   = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_hit[l]) begin
                win_lvl = PRIO_W'(l);
                win_idx = lvl_idx[l];
            end
        end
    end

    // R3: the winner is asserted, enabled and at the reported level.
    assert_winner_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (src_req[win_idx] && src_en[win_idx] && src_prio[win_idx] == win_lvl));

    // R4: no winner only when nothing enabled is asserted.
    assert_idle_means_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> ((src_req & src_en) == '0));
endmodule

// File: rtl/icoll_ack_tracker.sv
// Acknowledge tracker: holds the vector register and the in-service level set,
// and drives the registered processor interrupt. Assumes a take and a release
// never arrive in the same cycle (one bus write per cycle).
module icoll_ack_tracker
    import icoll_pkg::*;
#(
    parameter int SRC_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [SRC_W-1:0]   vec_new,
    input  logic [PRIO_W-1:0]  take_lvl,
    input  logic               lack_wr,
    input  logic [NUM_LVL-1:0] rel_mask,
    input  logic               gate,
    input  logic               win_valid,
    input  logic [PRIO_W-1:0]  win_lvl,
    output logic [SRC_W-1:0]   vec_q,
    output logic [NUM_LVL-1:0] isr_q,
    output logic               cpu_irq
);
    logic [PRIO_W-1:0] top_lvl;
    logic              irq_d;

    // Highest level currently in service.
    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (isr_q[l]) top_lvl = PRIO_W'(l);
        end
    end

    // Request the processor when a winner outranks everything in service.
    assign irq_d = !gate && win_valid && ((isr_q == '0) || (win_lvl > top_lvl));

    // Vector capture, in-service bookkeeping and interrupt register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            isr_q   <= '0;
            cpu_irq <= 1'b0;
        end else begin
            cpu_irq <= irq_d;
            if (take) begin
                vec_q           <= vec_new;
                isr_q[take_lvl] <= 1'b1;
            end else if (lack_wr) begin
                isr_q <= isr_q & ~rel_mask;
            end
        end
    end

    // R6: taking a vector marks its level in service.
    assert_take_marks_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> isr_q[$past(take_lvl)]);

    // R7: a level acknowledge clears the requested levels.
    assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lack_wr && !take) |=> ((isr_q & $past(rel_mask)) == '0));

    // R9: the gate keeps the processor interrupt low.
    assert_gate_holds_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> !cpu_irq);
endmodule

// File: rtl/irq_collector.sv
// Top: register decode with four access aliases per 16-byte slot, control
// register, status and read mux, and the bank, arbiter and tracker.
// Assumes at most one strobe per cycle, word-aligned register access, and
// src_irq synchronous to clk.
module irq_collector
    import icoll_pkg::*;
#(
    parameter int N_SRC  = 128,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_irq,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cpu_irq
);
    localparam int SRC_W     = $clog2(N_SRC);
    localparam int SLOT_W    = ADDR_W - 4;
    localparam int SLOT_VEC  = 0;
    localparam int SLOT_LACK = 1;
    localparam int SLOT_CTRL = 2;
    localparam int SLOT_STAT = 7;
    localparam int SLOT_SRC0 = 18;
    localparam int SOFT_BIT  = 31;
    localparam int GATE_BIT  = 30;
    localparam logic [SRC_W-1:0] NONE_CODE = '1;

    logic [SLOT_W-1:0] slot, src_off;
    acc_e              op;
    logic              aligned, hit_vec, hit_lack, hit_ctrl, hit_stat, hit_src;
    logic              soft_q, gate_q;
    logic [1:0]        ctrl_new;

    logic [N_SRC-1:0]             src_en;
    logic [N_SRC-1:0][PRIO_W-1:0] src_prio;
    logic [PRIO_W:0]              src_rd;
    logic                         win_valid;
    logic [PRIO_W-1:0]            win_lvl;
    logic [SRC_W-1:0]             win_idx;
    logic [SRC_W-1:0]             vec_q, vec_new;
    logic [NUM_LVL-1:0]           isr_q;
    logic [31:0]                  rd_mux;

    // Address split into slot number and alias selector.
    assign slot     = bus_addr[ADDR_W-1:4];
    assign op       = acc_e'(bus_addr[3:2]);
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign src_off  = slot - SLOT_W'(SLOT_SRC0);
    assign hit_vec  = aligned && slot == SLOT_W'(SLOT_VEC);
    assign hit_lack = aligned && slot == SLOT_W'(SLOT_LACK);
    assign hit_ctrl = aligned && slot == SLOT_W'(SLOT_CTRL);
    assign hit_stat = aligned && slot == SLOT_W'(SLOT_STAT);
    assign hit_src  = aligned && slot >= SLOT_W'(SLOT_SRC0) && src_off < SLOT_W'(N_SRC);

    // New control bits {soft, gate} after the alias operation.
    assign ctrl_new = 2'(apply_acc(op, {soft_q, gate_q, 30'b0}, bus_wdata) >> GATE_BIT);

    // New vector value after the alias operation.
    assign vec_new = SRC_W'(apply_acc(op, 32'(vec_q), bus_wdata));

    // Control register: soft reset and interrupt gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
            gate_q <= 1'b0;
        end else if (bus_wr && hit_ctrl) begin
            soft_q <= ctrl_new[1];
            gate_q <= ctrl_new[0];
        end
    end

    icoll_src_bank #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && hit_src),
        .wr_op    (op),
        .wr_idx   (src_off[SRC_W-1:0]),
        .wr_data  (bus_wdata),
        .soft_rst (soft_q),
        .src_en   (src_en),
        .src_prio (src_prio),
        .rd_val   (src_rd)
    );

    icoll_arbiter #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_irq),
        .src_en    (src_en),
        .src_prio  (src_prio),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .win_idx   (win_idx)
    );

    icoll_ack_tracker #(.SRC_W(SRC_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (bus_wr && hit_vec && (int'(vec_new) < N_SRC)),
        .vec_new   (vec_new),
        .take_lvl  (src_prio[vec_new]),
        .lack_wr   (bus_wr && hit_lack),
        .rel_mask  (bus_wdata[NUM_LVL-1:0]),
        .gate      (gate_q),
        .win_valid (win_valid),
        .win_lvl   (win_lvl),
        .vec_q     (vec_q),
        .isr_q     (isr_q),
        .cpu_irq   (cpu_irq)
    );

    // Read mux over all mapped registers; anything else reads zero.
    always_comb begin
        rd_mux = '0;
        if (hit_vec)       rd_mux = 32'(vec_q);
        else if (hit_lack) rd_mux = 32'(isr_q);
        else if (hit_ctrl) rd_mux = {soft_q, gate_q, 30'b0};
        else if (hit_stat) rd_mux = {win_valid, 31'(win_valid ? win_idx : NONE_CODE)};
        else if (hit_src)  rd_mux = 32'(src_rd);
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R2: a misaligned read returns zero.
    assert_unaligned_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !aligned) |=> (bus_rdata == 32'd0));
endmodule

// File: tb/tb_irq_collector.sv
`timescale 1ns/1ps
module tb_irq_collector;
    localparam int N = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_irq = '0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         cpu_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_collector #(.N_SRC(N), .ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] sa(input int n, input int alias_sel);
        return 12'(32'h120 + n * 16 + alias_sel * 4);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R10 irq after reset", 32'(cpu_irq), 0);
        rd(12'h070, v); chk("R10 status after reset", v, 32'h7F);
        rd(sa(5, 0), v); chk("R10 source reg after reset", v, 0);
        rd(12'h020, v); chk("R10 control after reset", v, 0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(sa(3, 0), 32'h5); rd(sa(3, 0), v); chk("R1 plain write", v, 32'h5);
        wr(sa(3, 1), 32'h2); rd(sa(3, 0), v); chk("R1 OR alias", v, 32'h7);
        wr(sa(3, 2), 32'h1); rd(sa(3, 0), v); chk("R1 clear alias", v, 32'h6);
        wr(sa(3, 3), 32'h3); rd(sa(3, 0), v); chk("R1 toggle alias", v, 32'h5);
        rd(sa(4, 0), v); chk("R1 neighbour untouched", v, 0);
        wr(sa(3, 0), 32'hFFFF_FFF8); rd(sa(3, 0), v); chk("R1 upper bits dropped", v, 0);
        wr(12'h024, 32'h4000_0000); rd(12'h020, v); chk("R1 control OR alias", v, 32'h4000_0000);
        wr(12'h028, 32'h4000_0000); rd(12'h020, v); chk("R1 control clear alias", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, v); chk("R2 unmapped reads zero", v, 0);
        rd(12'h020, v); chk("R2 unmapped write left control", v, 0);
        rd(12'h000, v); chk("R2 unmapped write left vector", v, 0);
        wr(12'h930, 32'h7); rd(sa(127, 0), v); chk("R2 write past last source ignored", v, 0);
        wr(12'h121, 32'h7); rd(sa(0, 0), v); chk("R2 misaligned write ignored", v, 0);
        wr(sa(0, 0), 32'h7); rd(12'h121, v); chk("R2 misaligned read zero", v, 0);
        wr(sa(0, 0), 32'h0);
    endtask

    task automatic t_arb();
        logic [31:0] v;
        wr(sa(10, 0), 32'h5); wr(sa(20, 0), 32'h6); wr(sa(30, 0), 32'h6);
        wr(sa(40, 0), 32'h2); wr(sa(5, 0), 32'h6); wr(sa(127, 0), 32'h7);
        src_irq[40] = 1'b1; settle();
        rd(12'h070, v); chk("R3 disabled source never wins", v, 32'h7F);
        chk("R3 no irq for disabled source", 32'(cpu_irq), 0);
        src_irq[10] = 1'b1; src_irq[20] = 1'b1; src_irq[30] = 1'b1;
        rd(12'h070, v); chk("R3 higher level beats lower", v, 32'h8000_0014);
        src_irq[20] = 1'b0;
        rd(12'h070, v); chk("R3 next winner at level 2", v, 32'h8000_001E);
        src_irq[5] = 1'b1;
        rd(12'h070, v); chk("R3 tie goes to lower number", v, 32'h8000_0005);
        src_irq[127] = 1'b1;
        rd(12'h070, v); chk("R4 source 127 flagged valid", v, 32'h8000_007F);
        src_irq = '0;
        rd(12'h070, v); chk("R4 none pending reads 0x7F", v, 32'h7F);
        wr(sa(10, 0), 0); wr(sa(20, 0), 0); wr(sa(30, 0), 0);
        wr(sa(40, 0), 0); wr(sa(5, 0), 0); wr(sa(127, 0), 0);
    endtask

    task automatic t_handshake();
        logic [31:0] v;
        wr(sa(8, 0), 32'h4); wr(sa(9, 0), 32'h4); wr(sa(12, 0), 32'h6);
        src_irq[8] = 1'b1; settle();
        chk("R5 irq raised for pending source", 32'(cpu_irq), 1);
        rd(12'h070, v); chk("R5 status names source 8", v, 32'h8000_0008);
        wr(12'h000, v); settle();
        chk("R6 irq dropped after vector write", 32'(cpu_irq), 0);
        rd(12'h010, v); chk("R7 level 0 in service", v, 32'h1);
        src_irq[9] = 1'b1; settle();
        chk("R6 same level held off", 32'(cpu_irq), 0);
        wr(12'h010, 32'h1); settle();
        rd(12'h010, v); chk("R7 value 1 releases level 0", v, 0);
        chk("R7 irq returns after release", 32'(cpu_irq), 1);
        wr(12'h000, 32'h8);
        src_irq[12] = 1'b1; settle();
        chk("R6 higher level preempts", 32'(cpu_irq), 1);
        rd(12'h070, v); chk("R3 level 2 source wins", v, 32'h8000_000C);
        wr(12'h000, v); settle();
        chk("R6 held off at level 2", 32'(cpu_irq), 0);
        rd(12'h010, v); chk("R7 levels 0 and 2 in service", v, 32'h5);
        rd(12'h000, v); chk("R6 vector reads back", v, 32'hC);
        wr(12'h010, 32'h4); settle();
        rd(12'h010, v); chk("R7 release of level 2 only", v, 32'h1);
        chk("R6 pending level 2 above level 0", 32'(cpu_irq), 1);
        src_irq = '0; wr(12'h010, 32'h1); settle();
        chk("R5 irq low when idle", 32'(cpu_irq), 0);
        wr(sa(8, 0), 0); wr(sa(9, 0), 0); wr(sa(12, 0), 0);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        wr(sa(50, 0), 32'h7); rd(sa(50, 0), v); chk("R8 setup", v, 32'h7);
        wr(12'h024, 32'h8000_0000); settle();
        rd(sa(50, 0), v); chk("R8 soft reset zeroes priority", v, 32'h4);
        wr(sa(50, 0), 32'h3); settle();
        rd(sa(50, 0), v); chk("R8 priority write ignored", v, 32'h0);
        wr(12'h028, 32'h8000_0000);
        wr(sa(50, 0), 32'h7); rd(sa(50, 0), v); chk("R8 priority writable again", v, 32'h7);
        wr(sa(50, 0), 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(sa(60, 0), 32'h5); src_irq[60] = 1'b1; settle();
        chk("R9 irq before gate", 32'(cpu_irq), 1);
        wr(12'h020, 32'h4000_0000); settle();
        chk("R9 gate holds irq low", 32'(cpu_irq), 0);
        rd(12'h070, v); chk("R9 status kept under gate", v, 32'h8000_003C);
        wr(12'h020, 32'h0); settle();
        chk("R9 irq back after gate", 32'(cpu_irq), 1);
        src_irq = '0; wr(sa(60, 0), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alias();
        t_unmapped();
        t_arb();
        t_handshake();
        t_soft();
        t_gate();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule